// File: doc/BRIEF.md
# Tracking Converter Servo Controller

This block is the digital half of a servo-style analog-to-digital converter. It owns an up/down counter whose value is the code sent to an external DAC. An external comparator reports one bit each clock: high when the analog input is above the DAC level, low otherwise. The counter steps one LSB toward the input on every enabled clock, so the code follows a slowly moving input without ever restarting a conversion.

Three modes reuse the same counter. Track mode follows the input in both directions. Minimum-capture mode blocks upward steps, so over a window the code can only fall and ends at the lowest level the input reached. Maximum-capture mode blocks downward steps and keeps the highest level. A hold input freezes the code and its flag for as long as it is high, which turns the block into a sample-and-hold with no droop.

The result leaves the block as a registered level with a valid flag and no ready input. The code drives the DAC on every cycle, so it cannot wait for a consumer. A consumer samples `code` whenever `valid` is high and cannot apply back-pressure. Stalling the value on purpose is the job of `hold`.

Top module: `tadc_servo_ctrl`

## Requirements
- R1: While `rst_n` is low, `code` is 0 and `valid` is 0.
- R2: In track mode (`mode` 2'b00, and also 2'b11), each enabled, non-held clock that does not start a window moves `code` up by one when `cmp_above` is 1 and down by one when it is 0.
- R3: `code` saturates at 0 and at 2^CODE_W-1 and never wraps around.
- R4: While `en` and `hold` are both high, `code` and `valid` keep their values, whatever the comparator and the mode do. When hold is released, counting resumes from the held code.
- R5: While `en` is low, `code` keeps its value and `valid` is 0.
- R6: In minimum-capture mode (`mode` 2'b01), a window start loads `code` with all ones, and after that `code` never increases.
- R7: In maximum-capture mode (`mode` 2'b10), a window start loads `code` with 0, and after that `code` never decreases.
- R8: A window starts on the first enabled, non-held clock after reset or after `en` was low, and on any enabled, non-held clock whose `mode` differs from the mode of the window that is running. That clock does not count. In track mode it leaves `code` unchanged.
- R9: A window start clears `valid`. In a capture mode, `valid` rises after the first counting clock. In track mode, `valid` rises when the comparator bit flips between two counting clocks, or when it pushes against a saturation limit. Once high, `valid` stays high until `en` goes low or a new window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_above | input | 1 | Comparator bit: 1 when the analog input is above the DAC level |
| en | input | 1 | Enables counting; low freezes the code and clears valid |
| hold | input | 1 | Freezes code and valid; takes priority over counting |
| mode | input | 2 | 00/11 track, 01 minimum capture, 10 maximum capture |
| code | output | CODE_W | Registered DAC code |
| valid | output | 1 | Code has locked onto or bounded the input |

## Verification
The bench closes the loop with a behavioural DAC and comparator. The comparator reports whether an integer input level is strictly above the code.

In track mode, a rising ramp and a falling step show that the code moves exactly one LSB per clock in each direction. An input left still shows the code dithering within one LSB of it. Inputs beyond both rails tell saturation apart from wrap-around.

In the capture modes, the input goes through a sequence of levels: a high level, then a lower one, then a partial recovery. This separates a counter with one direction blocked from a plain tracker, because only the blocked counter keeps the extreme value. A hold with a moving input shows that the code is frozen and that it resumes from the frozen value.

// File: rtl/tadc_pkg.sv
package tadc_pkg;
  typedef enum logic [1:0] {
    MODE_TRACK   = 2'b00,
    MODE_MIN     = 2'b01,
    MODE_MAX     = 2'b10,
    MODE_TRACK_B = 2'b11
  } tadc_mode_e;

  function automatic logic mode_is_track(input logic [1:0] m);
    return (m == MODE_TRACK) || (m == MODE_TRACK_B);
  endfunction
endpackage

// File: rtl/tadc_window.sv
// Decides when a counting window starts and whether this clock may act.
module tadc_window (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       hold,
  input  logic [1:0] mode,
  output logic       act,
  output logic       restart
);
  logic       run_q;
  logic [1:0] mode_q;

  assign act     = en && !hold;
  assign restart = act && (!run_q || (mode != mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 2'b00;
    end else if (!en) begin
      run_q  <= 1'b0;
    end else if (act) begin
      run_q  <= 1'b1;
      mode_q <= mode;
    end
  end
endmodule

// File: rtl/tadc_step.sv
// Saturating one-LSB step with per-mode direction inhibit.
module tadc_step
  import tadc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] cur,
  input  logic              cmp_above,
  input  logic [1:0]        mode,
  output logic [CODE_W-1:0] nxt,
  output logic              at_rail
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  logic up_ok, dn_ok;

  always_comb begin
    up_ok   = cmp_above  && (mode != MODE_MIN) && (cur != TOP);
    dn_ok   = !cmp_above && (mode != MODE_MAX) && (cur != '0);
    at_rail = (cmp_above && (cur == TOP)) || (!cmp_above && (cur == '0));
    if (up_ok)      nxt = cur + 1'b1;
    else if (dn_ok) nxt = cur - 1'b1;
    else            nxt = cur;
  end
endmodule

// File: rtl/tadc_lock.sv
// Valid flag: lock detection in track mode, first-step bound in capture modes.
module tadc_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic act,
  input  logic restart,
  input  logic is_track,
  input  logic cmp_above,
  input  logic at_rail,
  output logic valid
);
  logic prev_cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      prev_cmp_q <= 1'b0;
    end else if (!en) begin
      valid      <= 1'b0;
    end else if (act) begin
      prev_cmp_q <= cmp_above;
      if (restart)
        valid <= 1'b0;
      else if (!is_track || (cmp_above != prev_cmp_q) || at_rail)
        valid <= 1'b1;
    end
  end
endmodule

// File: rtl/tadc_servo_ctrl.sv
module tadc_servo_ctrl
  import tadc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_above,
  input  logic              en,
  input  logic              hold,
  input  logic [1:0]        mode,
  output logic [CODE_W-1:0] code,
  output logic              valid
);
  localparam logic [CODE_W-1:0] PRESET_MIN = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] PRESET_MAX = '0;

  logic              act, restart, at_rail;
  logic [CODE_W-1:0] step_nxt;

  tadc_window u_win (
    .clk(clk), .rst_n(rst_n), .en(en), .hold(hold), .mode(mode),
    .act(act), .restart(restart)
  );

  tadc_step #(.CODE_W(CODE_W)) u_step (
    .cur(code), .cmp_above(cmp_above), .mode(mode),
    .nxt(step_nxt), .at_rail(at_rail)
  );

  tadc_lock u_lock (
    .clk(clk), .rst_n(rst_n), .en(en), .act(act), .restart(restart),
    .is_track(mode_is_track(mode)), .cmp_above(cmp_above),
    .at_rail(at_rail), .valid(valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (act) begin
      if (restart) begin
        if (mode == MODE_MIN)      code <= PRESET_MIN;
        else if (mode == MODE_MAX) code <= PRESET_MAX;
      end else begin
        code <= step_nxt;
      end
    end
  end
endmodule

// File: rtl/tadc_servo_chk.sv
module tadc_servo_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_above,
  input logic              en,
  input logic              hold,
  input logic [1:0]        mode,
  input logic [CODE_W-1:0] code,
  input logic              valid
);
  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold) |=> ($stable(code) && $stable(valid)));

  // R5
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(code) && !valid));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold && $past(en && !hold) && (mode == $past(mode))) |=>
      (({1'b0, code} == {1'b0, $past(code)}) ||
       ({1'b0, code} == {1'b0, $past(code)} + 1'b1) ||
       ({1'b0, code} + 1'b1 == {1'b0, $past(code)})));

  // R6
  min_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold && mode == 2'b01 && $past(en && !hold && mode == 2'b01))
      |=> (code <= $past(code)));

  // R7
  max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold && mode == 2'b10 && $past(en && !hold && mode == 2'b10))
      |=> (code >= $past(code)));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold && cmp_above && (code == {CODE_W{1'b1}}) && mode != 2'b01
      && $past(en && !hold) && (mode == $past(mode))) |=> (code == {CODE_W{1'b1}}));
endmodule

bind tadc_servo_ctrl tadc_servo_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_above(cmp_above), .en(en), .hold(hold),
  .mode(mode), .code(code), .valid(valid)
);

// File: tb/sim_tadc_servo_ctrl.sv
module sim_tadc_servo_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         hold = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         cmp_above;
  logic [W-1:0] code;
  logic         valid;
  int           vin = 0;
  int           n_run = 0;
  int           n_fail = 0;
  int           cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural DAC and comparator
  always_comb cmp_above = (vin > int'(code));

  tadc_servo_ctrl #(.CODE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_above(cmp_above), .en(en), .hold(hold),
    .mode(mode), .code(code), .valid(valid)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 code in reset", int'(code), 0);
    chk("R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_track_up();
    vin = 40; mode = 2'b00; en = 1'b1;
    tick(1);
    chk("R8 track window start keeps code", int'(code), 0);
    chk("R9 valid cleared at start", int'(valid), 0);
    tick(20);
    chk("R2 one step per clock up", int'(code), 20);
    chk("R9 no lock while ramping", int'(valid), 0);
    tick(40);
    chk_near("R2 dither around input", int'(code), 39, 40);
    chk("R9 lock after reversal", int'(valid), 1);
  endtask

  task automatic t_track_down();
    int c;
    vin = 10;
    c = int'(code);
    tick(5);
    chk("R2 one step per clock down", int'(code), c - 5);
    tick(60);
    chk_near("R2 settles low", int'(code), 9, 10);
  endtask

  task automatic t_rails();
    int c;
    en = 1'b0;
    c = int'(code);
    vin = 300;
    tick(3);
    chk("R5 code frozen when disabled", int'(code), c);
    chk("R5 valid low when disabled", int'(valid), 0);
    en = 1'b1;
    tick(1);
    tick(300);
    chk("R3 top saturation", int'(code), 255);
    chk("R9 valid from rail push", int'(valid), 1);
    tick(5);
    chk("R3 no wrap at top", int'(code), 255);
    vin = -20;
    tick(300);
    chk("R3 bottom saturation", int'(code), 0);
    tick(5);
    chk("R3 no wrap at bottom", int'(code), 0);
  endtask

  task automatic t_hold();
    int c;
    int v;
    vin = 100;
    tick(120);
    chk_near("R2 tracks to 100", int'(code), 99, 100);
    hold = 1'b1;
    c = int'(code);
    v = int'(valid);
    vin = 20;
    tick(30);
    chk("R4 code frozen in hold", int'(code), c);
    chk("R4 valid frozen in hold", int'(valid), v);
    hold = 1'b0;
    tick(1);
    chk("R4 resumes from held code", int'(code), c - 1);
  endtask

  task automatic t_min();
    mode = 2'b01; vin = 200;
    tick(1);
    chk("R6 min preset all ones", int'(code), 255);
    chk("R9 valid cleared on mode change", int'(valid), 0);
    tick(1);
    chk("R9 capture valid after first step", int'(valid), 1);
    tick(100);
    chk("R6 min bound level 200", int'(code), 199);
    vin = 120;
    tick(100);
    chk("R6 min follows lower input", int'(code), 119);
    vin = 180;
    tick(40);
    chk("R6 min never rises", int'(code), 119);
  endtask

  task automatic t_max();
    mode = 2'b10; vin = 50;
    tick(1);
    chk("R7 max preset zero", int'(code), 0);
    tick(80);
    chk("R7 max reaches 50", int'(code), 50);
    vin = 90;
    tick(60);
    chk("R7 max follows higher input", int'(code), 90);
    vin = 30;
    tick(60);
    chk("R7 max never falls", int'(code), 90);
  endtask

  task automatic t_track_alt();
    mode = 2'b11; vin = 30;
    tick(1);
    chk("R8 new track window keeps code", int'(code), 90);
    tick(10);
    chk("R2 mode 11 tracks down", int'(code), 80);
  endtask

  initial begin
    t_reset();
    t_track_up();
    t_track_down();
    t_rails();
    t_hold();
    t_min();
    t_max();
    t_track_alt();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule